// File: doc/BRIEF.md
# Configurable Nibble Port with Handshake Strobes

This block is an eight-bit bidirectional port for a microcontroller. The port is split into two four-bit halves, and a mode register sets each half on its own. A half can drive the port data register, sample its pins, or carry the high byte of an external memory address. The register bus reads and writes the data register and the mode register, and it reads a status word. When an external memory address is on the port and another master asserts bus release, the port stops driving all eight pins.

Handshake mode uses two strobe lines that the port borrows from a neighbouring port: an active-low data-valid line and a ready line. The direction programmed for the upper half picks the transfer direction, and the lower half is made to follow that direction. A build parameter states whether the chip has an internal program ROM. Reset configures the port from that parameter: without a ROM the port comes out driving the address with slow bus timing set, and with a ROM it comes out as inputs. Each pin that nothing drives reads as the last level it held.

Top module: `nibble_port`

## Requirements
- R1: With `ROMLESS`=0, reset leaves the mode register at 0x05, both halves as inputs, `pad_oe` at 0x00 and `ext_timing` low.
- R2: With `ROMLESS`=1, reset leaves the mode register at 0x2A. Both halves are in address mode, `pad_oe` is 0xFF, `pad_out` equals `ext_addr[15:8]` and `ext_timing` is high. A later mode write can clear that flag through bit 5.
- R3: The mode register is laid out as follows. Bits [1:0] set the lower half and bits [3:2] set the upper half: 00 is output, 01 is input, 10 is address, and 11 acts as input. Bit 4 enables handshake and bit 5 is the slow-timing flag.
  - An output half drives its data register nibble with enable set.
  - An input half has enable clear and returns its pin levels when the data register (select 0) is read.
- R4: In address mode the lower half drives `ext_addr[11:8]` and the upper half drives `ext_addr[15:12]`. Reading the data register returns 0 for an address half. With a 12-bit space, the upper half may be set to output or input independently of the lower half.
- R5: Suppose handshake is enabled, the upper half is not in address mode, and the lower half's decoded mode differs from the upper half's.
  - The lower half then takes the upper half's direction.
  - The status bit 2 (configuration error) is set by that mode write.
  - Any later mode write without the conflict clears the bit.
- R6: While either half is in address mode and `bus_release` is high, `pad_oe` is 0x00.
- R7: Output handshake (handshake enabled, upper half output) runs in this order:
  - A data write latches the data and drives `hs_dav_n_o` low one cycle later.
  - After a cycle that samples `hs_rdy_i` high, `hs_dav_n_o` returns high.
  - The port stays busy (status bit 0) until a cycle samples `hs_rdy_i` low.
  - Data writes made while the port is busy are ignored.
- R8: Input handshake (handshake enabled, upper half input) runs in this order:
  - `hs_rdy_o` is high while the input latch is empty.
  - A clock that sees `hs_dav_n_i` fall captures the pins into the latch, sets status bit 1 and drops `hs_rdy_o`.
  - Falling edges while the latch is full are ignored.
  - A data register read returns the latch and empties it.
- R9: A pin flagged by `pad_hiz` reads as the last value sampled on it while it was driven. After reset it reads 0.
- R10: Register select 1 reads the mode register with bits 7:6 zero. Select 2 reads status as {5'b0, config error, latch full, busy}. Select 3 reads 0.
- R11: `hs_dir_out` is high when the upper half is output. When handshake is off or the upper half is address, `hs_dav_n_o` stays high and `hs_rdy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (empties input latch on data read) |
| cpu_sel | input | 2 | Register select: 0 data, 1 mode, 2 status |
| cpu_wdata | input | W | Write data |
| cpu_rdata | output | W | Read data for the selected register |
| ext_addr | input | ADDR_W | External memory address |
| bus_release | input | 1 | Another master owns the bus |
| pad_oe | output | W | Per-pin output enable |
| pad_out | output | W | Per-pin output value |
| pad_in | input | W | Pin levels |
| pad_hiz | input | W | Pin not externally driven |
| hs_dav_n_i | input | 1 | Incoming data-valid strobe, active low |
| hs_dav_n_o | output | 1 | Outgoing data-valid strobe, active low |
| hs_rdy_i | input | 1 | Incoming ready |
| hs_rdy_o | output | 1 | Outgoing ready |
| hs_dir_out | output | 1 | Handshake runs in the output direction |
| ext_timing | output | 1 | Slow external bus timing flag |

## Verification
Random mode words over all four codes for each half are checked together with random data, addresses, pin levels and bus release. Comparing `pad_oe`, the driven `pad_out` bits and the read-back against a model tells a swapped nibble, a wrong address slice and a wrong decode of code 11 apart. Directed sequences drive the handshake both ways. They show whether a write while busy, or a data-valid edge while the latch is full, leaks through. Mismatched handshake modes confirm the lower-half forcing and the error flag, and a driven-then-floating pin sequence shows whether the keeper holds.

// File: rtl/np_pkg.sv
package np_pkg;
  typedef enum logic [1:0] {
    NM_OUT  = 2'b00,
    NM_IN   = 2'b01,
    NM_ADDR = 2'b10,
    NM_RSV  = 2'b11
  } nib_mode_t;

  typedef enum logic [1:0] {
    HO_IDLE      = 2'b00,
    HO_WAIT_RDY  = 2'b01,
    HO_WAIT_DROP = 2'b10
  } ho_state_t;

  localparam logic [1:0] SEL_DATA   = 2'd0;
  localparam logic [1:0] SEL_MODE   = 2'd1;
  localparam logic [1:0] SEL_STATUS = 2'd2;

  // code 11 is treated as input
  function automatic nib_mode_t nm_decode(input logic [1:0] code);
    return (code == 2'b11) ? NM_IN : nib_mode_t'(code);
  endfunction

  function automatic logic [5:0] np_reset_mode(input bit romless);
    return romless ? 6'b10_1010 : 6'b00_0101;
  endfunction

  function automatic logic nm_hs_active(input logic hs_en, input nib_mode_t up);
    return hs_en && (up != NM_ADDR);
  endfunction

  function automatic nib_mode_t nm_lower_eff(input nib_mode_t lo, input nib_mode_t up,
                                             input logic hs_act);
    return hs_act ? up : lo;
  endfunction

  function automatic logic np_cfg_conflict(input logic [5:0] m);
    return nm_hs_active(m[4], nm_decode(m[3:2])) && (nm_decode(m[1:0]) != nm_decode(m[3:2]));
  endfunction
endpackage

// File: rtl/np_keeper.sv
module np_keeper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] pin_hiz,
  output logic [W-1:0] pin_val
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= 1'b0;
      else if (!pin_hiz[i]) held_q <= pin_in[i];
    end
    assign pin_val[i] = pin_hiz[i] ? held_q : pin_in[i];
  end
endmodule

// File: rtl/np_nib_drive.sv
module np_nib_drive
  import np_pkg::*;
#(
  parameter int NIB = 4
) (
  input  nib_mode_t      mode,
  input  logic [NIB-1:0] data,
  input  logic [NIB-1:0] addr,
  input  logic           release_all,
  output logic [NIB-1:0] oe,
  output logic [NIB-1:0] out
);
  always_comb begin
    oe  = '0;
    out = '0;
    case (mode)
      NM_OUT: begin
        oe  = release_all ? '0 : '1;
        out = data;
      end
      NM_ADDR: begin
        oe  = release_all ? '0 : '1;
        out = addr;
      end
      default: begin
        oe  = '0;
        out = '0;
      end
    endcase
  end
endmodule

// File: rtl/np_hs_out.sv
module np_hs_out
  import np_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic start,
  input  logic rdy_i,
  output logic dav_n_o,
  output logic busy,
  output logic accept
);
  ho_state_t st_q;

  assign accept  = active && start && (st_q == HO_IDLE);
  assign busy    = (st_q != HO_IDLE);
  assign dav_n_o = !(active && st_q == HO_WAIT_RDY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HO_IDLE;
    else if (!active) st_q <= HO_IDLE;
    else begin
      case (st_q)
        HO_IDLE:      if (start) st_q <= HO_WAIT_RDY;
        HO_WAIT_RDY:  if (rdy_i) st_q <= HO_WAIT_DROP;
        HO_WAIT_DROP: if (!rdy_i) st_q <= HO_IDLE;
        default:      st_q <= HO_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/np_hs_in.sv
module np_hs_in #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         dav_n_i,
  input  logic         rd,
  input  logic [W-1:0] pin_data,
  output logic [W-1:0] latch,
  output logic         full,
  output logic         rdy_o
);
  logic dav_prev_q;
  logic dav_fall;

  assign dav_fall = dav_prev_q && !dav_n_i;
  assign rdy_o    = active && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dav_prev_q <= 1'b1;
      full       <= 1'b0;
      latch      <= '0;
    end else begin
      dav_prev_q <= dav_n_i;
      if (!active) full <= 1'b0;
      else begin
        if (rd) full <= 1'b0;
        if (dav_fall && !full) begin
          full  <= 1'b1;
          latch <= pin_data;
        end
      end
    end
  end
endmodule

// File: rtl/nibble_port.sv
module nibble_port
  import np_pkg::*;
#(
  parameter bit ROMLESS = 1'b0,
  parameter int W       = 8,
  parameter int ADDR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_sel,
  input  logic [W-1:0]      cpu_wdata,
  output logic [W-1:0]      cpu_rdata,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              bus_release,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  input  logic [W-1:0]      pad_in,
  input  logic [W-1:0]      pad_hiz,
  input  logic              hs_dav_n_i,
  output logic              hs_dav_n_o,
  input  logic              hs_rdy_i,
  output logic              hs_rdy_o,
  output logic              hs_dir_out,
  output logic              ext_timing
);
  localparam int NIB    = W / 2;
  localparam int A_BASE = ADDR_W - W;

  logic [5:0]   mode_q;
  logic         cfg_err_q;
  logic [W-1:0] data_q;

  nib_mode_t up_m, lo_raw, lo_m;
  nib_mode_t nm [2];
  logic hs_act, out_hs_act, in_hs_act, any_addr, release_all;
  logic wr_data, wr_mode, rd_data;
  logic busy, accept, full;
  logic [W-1:0] pin_val, in_latch, data_rd;

  assign up_m        = nm_decode(mode_q[3:2]);
  assign lo_raw      = nm_decode(mode_q[1:0]);
  assign hs_act      = nm_hs_active(mode_q[4], up_m);
  assign lo_m        = nm_lower_eff(lo_raw, up_m, hs_act);
  assign out_hs_act  = hs_act && (up_m == NM_OUT);
  assign in_hs_act   = hs_act && (up_m == NM_IN);
  assign any_addr    = (lo_m == NM_ADDR) || (up_m == NM_ADDR);
  assign release_all = bus_release && any_addr;
  assign nm[0]       = lo_m;
  assign nm[1]       = up_m;
  assign hs_dir_out  = (up_m == NM_OUT);
  assign ext_timing  = mode_q[5];

  assign wr_data = cpu_wr && (cpu_sel == SEL_DATA);
  assign wr_mode = cpu_wr && (cpu_sel == SEL_MODE);
  assign rd_data = cpu_rd && (cpu_sel == SEL_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= np_reset_mode(ROMLESS);
      cfg_err_q <= 1'b0;
      data_q    <= '0;
    end else begin
      if (wr_mode) begin
        mode_q    <= cpu_wdata[5:0];
        cfg_err_q <= np_cfg_conflict(cpu_wdata[5:0]);
      end
      if (wr_data && (!out_hs_act || accept)) data_q <= cpu_wdata;
    end
  end

  np_keeper #(.W(W)) u_keep (
    .clk(clk), .rst_n(rst_n), .pin_in(pad_in), .pin_hiz(pad_hiz), .pin_val(pin_val)
  );

  np_hs_out u_hso (
    .clk(clk), .rst_n(rst_n), .active(out_hs_act), .start(wr_data), .rdy_i(hs_rdy_i),
    .dav_n_o(hs_dav_n_o), .busy(busy), .accept(accept)
  );

  np_hs_in #(.W(W)) u_hsi (
    .clk(clk), .rst_n(rst_n), .active(in_hs_act), .dav_n_i(hs_dav_n_i), .rd(rd_data),
    .pin_data(pin_val), .latch(in_latch), .full(full), .rdy_o(hs_rdy_o)
  );

  for (genvar k = 0; k < 2; k++) begin : g_nib
    np_nib_drive #(.NIB(NIB)) u_drv (
      .mode(nm[k]),
      .data(data_q[k*NIB +: NIB]),
      .addr(ext_addr[A_BASE + k*NIB +: NIB]),
      .release_all(release_all),
      .oe(pad_oe[k*NIB +: NIB]),
      .out(pad_out[k*NIB +: NIB])
    );
    always_comb begin
      case (nm[k])
        NM_OUT:  data_rd[k*NIB +: NIB] = data_q[k*NIB +: NIB];
        NM_ADDR: data_rd[k*NIB +: NIB] = '0;
        default: data_rd[k*NIB +: NIB] = pin_val[k*NIB +: NIB];
      endcase
    end
  end

  always_comb begin
    case (cpu_sel)
      SEL_DATA:   cpu_rdata = in_hs_act ? in_latch : data_rd;
      SEL_MODE:   cpu_rdata = W'(mode_q);
      SEL_STATUS: cpu_rdata = W'({cfg_err_q, full, busy});
      default:    cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/np_checker.sv
module np_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cpu_wr,
  input logic [1:0]   cpu_sel,
  input logic [W-1:0] cpu_wdata,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_out,
  input logic         hs_dav_n_i,
  input logic         hs_dav_n_o,
  input logic         hs_rdy_i,
  input logic         hs_rdy_o,
  input logic         out_hs_act,
  input logic         in_hs_act,
  input logic         release_all,
  input logic         busy,
  input logic         cfg_err_q
);
  localparam int NIB = W / 2;

  p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hs_act && busy && cpu_wr && cpu_sel == np_pkg::SEL_DATA) |=> $stable(pad_out));

  p_dav_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hs_act && !hs_dav_n_o && hs_rdy_i && !cpu_wr) |=> hs_dav_n_o);

  p_capture_drops_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hs_act && hs_rdy_o && $fell(hs_dav_n_i) && !cpu_wr) |=> !hs_rdy_o);

  p_release_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    release_all |-> (pad_oe == '0));

  p_lower_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hs_act || in_hs_act) |-> (pad_oe[NIB-1:0] == {NIB{pad_oe[W-1]}}));

  p_cfg_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_sel == np_pkg::SEL_MODE && np_pkg::np_cfg_conflict(cpu_wdata[5:0]))
    |=> cfg_err_q);
endmodule

bind nibble_port np_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
  .pad_oe(pad_oe), .pad_out(pad_out), .hs_dav_n_i(hs_dav_n_i), .hs_dav_n_o(hs_dav_n_o),
  .hs_rdy_i(hs_rdy_i), .hs_rdy_o(hs_rdy_o), .out_hs_act(out_hs_act), .in_hs_act(in_hs_act),
  .release_all(release_all), .busy(busy), .cfg_err_q(cfg_err_q)
);

// File: tb/sim_nibble_port.sv
`timescale 1ns/1ps
module sim_nibble_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0] cpu_sel = 2'd0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [15:0] ext_addr = 16'hC3A0;
  logic bus_release = 1'b0;
  logic [7:0] pad_in = 8'h00, pad_hiz = 8'h00;
  logic hs_dav_n_i = 1'b1, hs_rdy_i = 1'b0;
  logic [7:0] rdata0, oe0, out0, rdata1, oe1, out1;
  logic dav0, rdy0, dir0, ext0, dav1, rdy1, dir1, ext1;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nibble_port #(.ROMLESS(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(rdata0), .ext_addr(ext_addr), .bus_release(bus_release),
    .pad_oe(oe0), .pad_out(out0), .pad_in(pad_in), .pad_hiz(pad_hiz),
    .hs_dav_n_i(hs_dav_n_i), .hs_dav_n_o(dav0), .hs_rdy_i(hs_rdy_i), .hs_rdy_o(rdy0),
    .hs_dir_out(dir0), .ext_timing(ext0));

  nibble_port #(.ROMLESS(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(rdata1), .ext_addr(ext_addr), .bus_release(bus_release),
    .pad_oe(oe1), .pad_out(out1), .pad_in(pad_in), .pad_hiz(pad_hiz),
    .hs_dav_n_i(hs_dav_n_i), .hs_dav_n_o(dav1), .hs_rdy_i(hs_rdy_i), .hs_rdy_o(rdy1),
    .hs_dir_out(dir1), .ext_timing(ext1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    cpu_sel = sel; cpu_wdata = d; cpu_wr = 1'b1;
    tick();
    cpu_wr = 1'b0;
  endtask

  // bench model of one nibble: code -> 0 out, 1 in, 2 addr
  function automatic int kind(input logic [1:0] c);
    return (c == 2'b11) ? 1 : int'(c);
  endfunction

  function automatic logic [7:0] m_oe(input logic [5:0] m, input logic rel);
    logic [7:0] r = 8'h00;
    bit anyaddr = (kind(m[1:0]) == 2) || (kind(m[3:2]) == 2);
    if (rel && anyaddr) return 8'h00;
    if (kind(m[1:0]) != 1) r[3:0] = 4'hF;
    if (kind(m[3:2]) != 1) r[7:4] = 4'hF;
    return r;
  endfunction

  function automatic logic [7:0] m_out(input logic [5:0] m, input logic [7:0] d,
                                       input logic [15:0] a);
    logic [7:0] r = 8'h00;
    r[3:0] = (kind(m[1:0]) == 2) ? a[11:8]  : d[3:0];
    r[7:4] = (kind(m[3:2]) == 2) ? a[15:12] : d[7:4];
    return r;
  endfunction

  function automatic logic [7:0] m_rd(input logic [5:0] m, input logic [7:0] d,
                                      input logic [7:0] p);
    logic [7:0] r;
    case (kind(m[1:0])) 0: r[3:0] = d[3:0]; 1: r[3:0] = p[3:0]; default: r[3:0] = 4'h0; endcase
    case (kind(m[3:2])) 0: r[7:4] = d[7:4]; 1: r[7:4] = p[7:4]; default: r[7:4] = 4'h0; endcase
    return r;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 / R2 reset states
    cpu_sel = 2'd1; #1;
    chk("R1 mode", rdata0, 8'h05);
    chk("R1 oe", oe0, 8'h00);
    chk("R1 ext", ext0, 0);
    chk("R2 mode", rdata1, 8'h2A);
    chk("R2 oe", oe1, 8'hFF);
    chk("R2 out", out1, ext_addr[15:8]);
    chk("R2 ext", ext1, 1);
    bus_release = 1'b1; #1;
    chk("R6 release", oe1, 8'h00);
    chk("R1 release no effect on inputs", oe0, 8'h00);
    bus_release = 1'b0;
    // R9 keeper: reset value, hold 1, hold 0
    pad_hiz = 8'hFF; cpu_sel = 2'd0; #1;
    chk("R9 keeper reset", rdata0, 8'h00);
    pad_hiz = 8'h00; pad_in = 8'hF0; tick();
    pad_hiz = 8'hFF; pad_in = 8'h0F; tick();
    chk("R9 keeper hold", rdata0, 8'hF0);
    pad_hiz = 8'h0F; pad_in = 8'h3C; tick(); #0;
    chk("R9 keeper mixed", rdata0, 8'h30);
    pad_hiz = 8'h00;
    // R2 ext timing clearable
    wr(2'd1, 8'h0A);
    chk("R2 ext cleared", ext1, 0);

    // R3 R4 R6 R10 random mixed modes, handshake off
    for (int i = 0; i < 60; i++) begin
      logic [5:0] m; logic [7:0] d, p; logic rel;
      m = {2'b00, 4'($urandom)};
      if (i % 3 == 0) m[5] = 1'b1;
      d = 8'($urandom); p = 8'($urandom); rel = ($urandom % 4) == 0;
      ext_addr = 16'($urandom);
      wr(2'd1, {2'b00, m});
      wr(2'd0, d);
      pad_in = p; bus_release = rel; #1;
      chk("R3 R6 oe", oe0, m_oe(m, rel));
      chk("R3 R4 out", out0 & oe0, m_out(m, d, ext_addr) & oe0);
      cpu_sel = 2'd0; #1;
      chk("R3 R4 read", rdata0, m_rd(m, d, p));
      cpu_sel = 2'd1; #1;
      chk("R10 mode read", rdata0, {2'b00, m});
      chk("R3 ext flag", ext0, m[5]);
      bus_release = 1'b0;
    end
    cpu_sel = 2'd3; #1;
    chk("R10 sel3", rdata0, 8'h00);

    // R4 12-bit space: lower address, upper input
    ext_addr = 16'h5B00; pad_in = 8'h90;
    wr(2'd1, 8'h06);
    chk("R4 lower addr", out0[3:0], 4'hB);
    chk("R4 oe", oe0, 8'h0F);
    cpu_sel = 2'd0; #1;
    chk("R4 upper input", rdata0, 8'h90);

    // R11 handshake with upper address: inactive, no error
    wr(2'd1, 8'h18);
    chk("R11 dav idle", dav0, 1);
    chk("R11 rdy idle", rdy0, 0);
    cpu_sel = 2'd2; #1;
    chk("R5 no error when upper addr", rdata0, 8'h00);

    // R5 conflict: hs, upper out, lower in
    wr(2'd1, 8'h11);
    cpu_sel = 2'd2; #1;
    chk("R5 error flag", rdata0[2], 1);
    chk("R5 lower forced out", oe0, 8'hFF);
    chk("R11 dir out", dir0, 1);
    wr(2'd1, 8'h10);
    cpu_sel = 2'd2; #1;
    chk("R5 error cleared", rdata0[2], 0);

    // R7 output handshake
    hs_rdy_i = 1'b0;
    wr(2'd0, 8'h6D);
    chk("R7 dav low", dav0, 0);
    chk("R7 data out", out0, 8'h6D);
    cpu_sel = 2'd2; #1;
    chk("R7 busy", rdata0[0], 1);
    wr(2'd0, 8'h11);
    chk("R7 write while dav low ignored", out0, 8'h6D);
    hs_rdy_i = 1'b1; tick();
    chk("R7 dav released", dav0, 1);
    wr(2'd0, 8'h22);
    chk("R7 write before ready drop ignored", out0, 8'h6D);
    cpu_sel = 2'd2; #1;
    chk("R7 still busy", rdata0[0], 1);
    hs_rdy_i = 1'b0; tick();
    cpu_sel = 2'd2; #1;
    chk("R7 idle", rdata0[0], 0);
    chk("R7 dav high idle", dav0, 1);
    wr(2'd0, 8'hA7);
    chk("R7 next write accepted", out0, 8'hA7);
    hs_rdy_i = 1'b1; tick(); hs_rdy_i = 1'b0; tick();

    // R8 input handshake, lower given out -> forced input
    hs_dav_n_i = 1'b1;
    wr(2'd1, 8'h14);
    chk("R11 dir in", dir0, 0);
    chk("R8 rdy empty", rdy0, 1);
    chk("R5 lower forced in", oe0, 8'h00);
    pad_in = 8'hA5; hs_dav_n_i = 1'b0; tick();
    chk("R8 rdy drop", rdy0, 0);
    cpu_sel = 2'd2; #1;
    chk("R8 full flag", rdata0[1], 1);
    pad_in = 8'h3C; hs_dav_n_i = 1'b1; tick(); hs_dav_n_i = 1'b0; tick();
    cpu_sel = 2'd0; #1;
    chk("R8 edge while full ignored", rdata0, 8'hA5);
    cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;
    chk("R8 read empties", rdy0, 1);
    hs_dav_n_i = 1'b1; tick(); hs_dav_n_i = 1'b0; tick();
    cpu_sel = 2'd0; #1;
    chk("R8 second capture", rdata0, 8'h3C);
    chk("R11 dav idle in input", dav0, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule